// File: doc/BRIEF.md
# OTP Protection Register Controller

This block holds the one-time-programmable protection words of a parallel memory device together with the lock bits that guard them. The storage is built from flip-flops. A reset brings every cell to the erased state of a fresh part. The one exception is a factory lock bit, which comes up already programmed. A host issues one of two commands, each with a word address and 16 bits of data. The first programs an OTP word. The second programs one of the two lock registers. Programming can only clear bits: the new word is the bitwise AND of the stored word and the command data. A lock bit therefore cannot be undone once it is cleared.

The protected space is made of two parts. The first is a leading 128-bit register at word addresses 0x81 to 0x88, split into a lower half (0x81 to 0x84) and an upper half (0x85 to 0x88). The second is a set of sixteen further 128-bit registers at 0x8A to 0x109, with eight words per register. The lock registers sit at word addresses 0x80 and 0x89. Two sticky status flags report failures: one for program errors and one for lock violations. A busy output shows when the block is working on a command. A combinational read port returns OTP words and lock register contents.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset, both flags and `busy` are 0. Every OTP word reads 0xFFFF, the lock register at 0x80 reads 0xFFFE and the lock register at 0x89 reads 0xFFFF.
- R2: An accepted OTP program (`cmd_kind`=0) to an unlocked word leaves that word equal to old AND data. No flag is set, and all other words are unchanged.
- R3: An OTP program to an address outside 0x81–0x88 and 0x8A–0x109 sets `err_prog` only. It does not set `err_lock`, and no stored content changes.
- R4: An OTP program to a word in a locked region sets both `err_prog` and `err_lock`, and the word keeps its old value.
- R5: The lower half of the first register (0x81–0x84) is locked from reset, because bit 0 of lock register 0x80 comes up as 0.
- R6: A lock bit is active when it is 0. Bit 1 of lock register 0x80 locks words 0x85–0x88. Bit n of lock register 0x89 locks words 0x8A+8n to 0x8A+8n+7.
- R7: A lock program (`cmd_kind`=1) to 0x80 or 0x89 ANDs the data into that register, so a 0 bit can never return to 1.
- R8: A lock program to any other address sets `err_prog` only and changes no stored content.
- R9: The flags stay set until `clr_status` is high on a clock edge, and that edge clears both flags. A flag that is being set on the same edge as a clear wins over the clear.
- R10: A command is accepted when `cmd_valid` is high and `busy` is low. After an accepted command, `busy` is high for exactly BUSY_CYCLES cycles. A command presented while `busy` is high is ignored.
- R11: `rd_data` shows the addressed OTP word or lock register in the same cycle. Any other address reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 1 | 0 = program OTP word, 1 = program lock register |
| cmd_addr | input | 9 | Word address of the command |
| cmd_data | input | 16 | Data ANDed into the target |
| clr_status | input | 1 | Clears both error flags |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 16 | Read data, combinational |
| busy | output | 1 | Command in progress |
| err_prog | output | 1 | Sticky program-error flag |
| err_lock | output | 1 | Sticky lock-error flag |

## Verification
The assertions assume that reset is applied before any command is issued, and that `cmd_kind`, `cmd_addr` and `cmd_data` are stable while `cmd_valid` is high. They also assume that `clr_status` is the only source of flag clearing. The stimulus changes inputs only on falling edges and holds each command for one cycle. It then waits for `busy` to drop before issuing the next one. The exception is one deliberate overlap, which checks that a command presented while busy is ignored. The address sweeps cover the whole 9-bit space, so the out-of-range checks include the two lock addresses themselves.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ADDR_W    = 9;
    localparam int unsigned WIDX_W    = 8;
    localparam int unsigned REGION_W  = 5;
    localparam int unsigned REG_WORDS = 8;
    localparam int unsigned HALF_WORDS = 4;

    localparam logic [ADDR_W-1:0] LOCK0_ADDR = 9'h080;
    localparam logic [ADDR_W-1:0] LOCK1_ADDR = 9'h089;
    localparam logic [ADDR_W-1:0] HEAD_BASE  = 9'h081;
    localparam logic [ADDR_W-1:0] EXT_BASE   = 9'h08A;

    localparam logic [DATA_W-1:0] LOCK0_INIT = 16'hFFFE;

    typedef enum logic {
        CMD_PROG_OTP  = 1'b0,
        CMD_PROG_LOCK = 1'b1
    } cmd_kind_e;

    typedef struct packed {
        logic                is_otp;
        logic                is_lock0;
        logic                is_lock1;
        logic [WIDX_W-1:0]   word;
        logic [REGION_W-1:0] region;
    } addr_dec_t;

    function automatic int unsigned region_count(input int unsigned n_ext);
        return 2 + n_ext;
    endfunction

    function automatic int unsigned word_count(input int unsigned n_ext);
        return REG_WORDS * (1 + n_ext);
    endfunction

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
    import otp_pkg::*;
#(
    parameter int unsigned NUM_EXT = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_dec_t         dec
);
    localparam int unsigned HEAD_END = 32'(HEAD_BASE) + REG_WORDS;
    localparam int unsigned EXT_END  = 32'(EXT_BASE) + REG_WORDS * NUM_EXT;

    logic [ADDR_W-1:0] head_off;
    logic [ADDR_W-1:0] ext_off;

    assign head_off = addr - HEAD_BASE;
    assign ext_off  = addr - EXT_BASE;

    always_comb begin
        dec = '0;
        if (addr == LOCK0_ADDR) begin
            dec.is_lock0 = 1'b1;
        end else if (addr == LOCK1_ADDR) begin
            dec.is_lock1 = 1'b1;
        end else if (addr >= HEAD_BASE && 32'(addr) < HEAD_END) begin
            dec.is_otp = 1'b1;
            dec.word   = WIDX_W'(head_off);
            dec.region = (32'(head_off) >= HALF_WORDS) ? REGION_W'(1) : REGION_W'(0);
        end else if (addr >= EXT_BASE && 32'(addr) < EXT_END) begin
            dec.is_otp = 1'b1;
            dec.word   = WIDX_W'(ext_off) + WIDX_W'(REG_WORDS);
            dec.region = REGION_W'(ext_off >> 3) + REGION_W'(2);
        end
    end
endmodule

// File: rtl/otp_lock_regs.sv
module otp_lock_regs
    import otp_pkg::*;
#(
    parameter int unsigned NUM_EXT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we0,
    input  logic                  we1,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     lock0,
    output logic [DATA_W-1:0]     lock1,
    output logic [region_count(NUM_EXT)-1:0] locked
);
    localparam int unsigned NREG = region_count(NUM_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock0 <= LOCK0_INIT;
            lock1 <= '1;
        end else begin
            if (we0) lock0 <= lock0 & wdata;
            if (we1) lock1 <= lock1 & wdata;
        end
    end

    assign locked[0] = ~lock0[0];
    assign locked[1] = ~lock0[1];

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext_lock
        assign locked[2+g] = ~lock1[g];
    end

    // R7: lock bits never return from 0 to 1
    p_lock_monotone_r7: assert property (@(posedge clk) disable iff (rst)
        ((lock0 & ~$past(lock0)) == '0) && ((lock1 & ~$past(lock1)) == '0));

    // R5: the factory lock of the lower half stays in force
    p_factory_lock_r5: assert property (@(posedge clk) disable iff (rst)
        locked[0]);
endmodule

// File: rtl/otp_word_array.sv
module otp_word_array
    import otp_pkg::*;
#(
    parameter int unsigned WORDS = 136
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WIDX_W-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (we) begin
            mem[widx] <= mem[widx] & wdata;
        end
    end

    assign rdata = mem[ridx];

    // R2: a programmed word holds 0 wherever the data had 0
    p_prog_clears_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> ((mem[$past(widx)] & ~$past(wdata)) == '0));
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned NUM_EXT     = 16,
    parameter int unsigned BUSY_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic        cmd_kind,
    input  logic [8:0]  cmd_addr,
    input  logic [15:0] cmd_data,
    input  logic        clr_status,
    input  logic [8:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        err_prog,
    output logic        err_lock
);
    localparam int unsigned NREG  = region_count(NUM_EXT);
    localparam int unsigned WORDS = word_count(NUM_EXT);
    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

    addr_dec_t          cdec, rdec;
    logic [DATA_W-1:0]  lock0, lock1, arr_rdata;
    logic [NREG-1:0]    locked;
    logic [CNT_W-1:0]   busy_cnt;
    logic               accept, is_otp_cmd, is_lock_cmd;
    logic               arr_we, lk_we0, lk_we1, set_prog, set_lock;

    otp_addr_decode #(.NUM_EXT(NUM_EXT)) u_cdec (.addr(cmd_addr), .dec(cdec));
    otp_addr_decode #(.NUM_EXT(NUM_EXT)) u_rdec (.addr(rd_addr),  .dec(rdec));

    otp_lock_regs #(.NUM_EXT(NUM_EXT)) u_locks (
        .clk(clk), .rst(rst), .we0(lk_we0), .we1(lk_we1), .wdata(cmd_data),
        .lock0(lock0), .lock1(lock1), .locked(locked)
    );

    otp_word_array #(.WORDS(WORDS)) u_array (
        .clk(clk), .rst(rst), .we(arr_we), .widx(cdec.word), .wdata(cmd_data),
        .ridx(rdec.word), .rdata(arr_rdata)
    );

    assign busy        = (busy_cnt != '0);
    assign accept      = cmd_valid && !busy;
    assign is_otp_cmd  = accept && (cmd_kind_e'(cmd_kind) == CMD_PROG_OTP);
    assign is_lock_cmd = accept && (cmd_kind_e'(cmd_kind) == CMD_PROG_LOCK);

    always_comb begin
        arr_we   = 1'b0;
        lk_we0   = 1'b0;
        lk_we1   = 1'b0;
        set_prog = 1'b0;
        set_lock = 1'b0;
        if (is_otp_cmd) begin
            if (!cdec.is_otp) begin
                set_prog = 1'b1;
            end else if (locked[cdec.region]) begin
                set_prog = 1'b1;
                set_lock = 1'b1;
            end else begin
                arr_we = 1'b1;
            end
        end else if (is_lock_cmd) begin
            if (cdec.is_lock0)      lk_we0   = 1'b1;
            else if (cdec.is_lock1) lk_we1   = 1'b1;
            else                    set_prog = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            err_prog <= 1'b0;
            err_lock <= 1'b0;
        end else begin
            if (accept)         busy_cnt <= CNT_W'(BUSY_CYCLES);
            else if (busy)      busy_cnt <= busy_cnt - 1'b1;
            err_prog <= (err_prog && !clr_status) || set_prog;
            err_lock <= (err_lock && !clr_status) || set_lock;
        end
    end

    always_comb begin
        if (rdec.is_otp)        rd_data = arr_rdata;
        else if (rdec.is_lock0) rd_data = lock0;
        else if (rdec.is_lock1) rd_data = lock1;
        else                    rd_data = '0;
    end

    // R10: an accepted command starts a busy window
    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R10: nothing presented while busy can touch the flags
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr_status) |=> ($stable(err_prog) && $stable(err_lock)));

    // R3: out-of-range OTP program raises the program error
    p_out_of_range_r3: assert property (@(posedge clk) disable iff (rst)
        (is_otp_cmd && !cdec.is_otp) |=> err_prog);

    // R4: locked target raises both flags
    p_locked_target_r4: assert property (@(posedge clk) disable iff (rst)
        (is_otp_cmd && cdec.is_otp && locked[cdec.region]) |=> (err_prog && err_lock));

    // R8: lock program to a foreign address leaves the lock registers alone
    p_bad_lock_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (is_lock_cmd && !cdec.is_lock0 && !cdec.is_lock1)
            |=> (err_prog && $stable(lock0) && $stable(lock1)));

    // R9: flags are sticky without a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ((err_prog || err_lock) && !clr_status)
            |=> ((err_prog || !$past(err_prog)) && (err_lock || !$past(err_lock))));
endmodule

// File: tb/tb_otp_prot_ctrl.sv
`timescale 1ns/1ps
module tb_otp_prot_ctrl;
    localparam int BUSY_N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_kind = 1'b0;
    logic [8:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        clr_status = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy, err_prog, err_lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_mem [512];
    logic [15:0] m_lk0, m_lk1;
    logic        m_ep, m_el;

    otp_prot_ctrl #(.NUM_EXT(16), .BUSY_CYCLES(BUSY_N)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .clr_status(clr_status),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .err_prog(err_prog), .err_lock(err_lock)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit in_otp(input int a);
        return (a >= 'h81 && a <= 'h88) || (a >= 'h8A && a <= 'h109);
    endfunction

    function automatic bit is_locked(input int a);
        if (a <= 'h84) return !m_lk0[0];
        if (a <= 'h88) return !m_lk0[1];
        return !m_lk1[(a - 'h8A) / 8];
    endfunction

    function automatic logic [15:0] m_read(input int a);
        if (a == 'h80) return m_lk0;
        if (a == 'h89) return m_lk1;
        if (in_otp(a)) return m_mem[a];
        return 16'h0000;
    endfunction

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = 9'(a);
        #1 v = rd_data;
    endtask

    task automatic sweep(input string req);
        logic [15:0] v;
        for (int a = 0; a < 512; a++) begin
            rd(a, v);
            chk(req, {16'h0, v}, {16'h0, m_read(a)});
        end
    endtask

    task automatic flags(input string req);
        chk(req, {30'h0, err_prog, err_lock}, {30'h0, m_ep, m_el});
    endtask

    task automatic cmd(input bit kind, input int a, input logic [15:0] d, input string req);
        int n = 0;
        if (!kind) begin
            if (!in_otp(a)) m_ep = 1;
            else if (is_locked(a)) begin m_ep = 1; m_el = 1; end
            else m_mem[a] = m_mem[a] & d;
        end else begin
            if (a == 'h80) m_lk0 = m_lk0 & d;
            else if (a == 'h89) m_lk1 = m_lk1 & d;
            else m_ep = 1;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_addr = 9'(a); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin n++; @(negedge clk); end
        chk("R10", n, BUSY_N);
        flags(req);
    endtask

    task automatic clear();
        @(negedge clk); clr_status = 1'b1;
        @(negedge clk); clr_status = 1'b0;
        m_ep = 0; m_el = 0;
        flags("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int a = 0; a < 512; a++) m_mem[a] = 16'hFFFF;
        m_lk0 = 16'hFFFE; m_lk1 = 16'hFFFF; m_ep = 0; m_el = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {29'h0, busy, err_prog, err_lock}, 32'h0);
        sweep("R1 R11");

        // R2 R4 R5: program every OTP word, lower half of the first register fails
        for (int a = 'h81; a <= 'h109; a++) begin
            if (a == 'h89) continue;
            cmd(0, a, 16'hFFFF ^ (16'h1 << (a % 16)), (a <= 'h84) ? "R5 R4" : "R2");
            if (m_ep) clear();
        end
        // second pattern onto the same words: AND behaviour
        for (int a = 'h85; a <= 'h99; a++) begin
            if (a == 'h89) continue;
            cmd(0, a, 16'h0F0F ^ 16'(a), "R2");
        end
        sweep("R2");

        // R3: addresses outside the OTP space
        foreach (m_lk0[i]) ; // no-op keeps the loop structure simple
        begin
            int bad [6] = '{'h000, 'h07F, 'h080, 'h089, 'h10A, 'h1FF};
            foreach (bad[i]) begin
                cmd(0, bad[i], 16'h0000, "R3");
                chk("R3", {31'h0, err_lock}, 32'h0);
                clear();
            end
        end
        sweep("R3");

        // R9: flag held over idle cycles, then cleared; set beats clear on same edge
        cmd(0, 'h000, 16'h0, "R9");
        repeat (10) @(negedge clk);
        flags("R9");
        clear();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 1'b0; cmd_addr = 9'h000; clr_status = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; clr_status = 1'b0;
        m_ep = 1;
        while (busy) @(negedge clk);
        flags("R9");
        clear();

        // R6: lock upper half of the first register
        cmd(1, 'h80, 16'hFFFD, "R6");
        rd('h80, v); chk("R6", v, 16'hFFFC);
        cmd(0, 'h85, 16'h0000, "R6");
        cmd(0, 'h88, 16'h0000, "R6");
        clear();
        // R6: lock register 1 bits
        for (int n = 0; n < 16; n += 5) begin
            cmd(1, 'h89, 16'hFFFF ^ (16'h1 << n), "R6");
            cmd(0, 'h8A + 8*n, 16'h0000, "R6");
            cmd(0, 'h8A + 8*n + 7, 16'h0000, "R6");
            clear();
            if (n < 15) cmd(0, 'h8A + 8*(n+1), 16'h00FF, "R6");
        end
        sweep("R6");

        // R7: writing ones cannot unlock
        cmd(1, 'h80, 16'hFFFF, "R7");
        cmd(1, 'h89, 16'hFFFF, "R7");
        rd('h80, v); chk("R7", v, 16'hFFFC);
        rd('h89, v); chk("R7", v, m_lk1);
        cmd(0, 'h86, 16'h0000, "R7");
        clear();

        // R8: lock program to wrong addresses
        begin
            int badl [4] = '{'h081, 'h08A, 'h000, 'h1FF};
            foreach (badl[i]) begin
                cmd(1, badl[i], 16'h0000, "R8");
                chk("R8", {31'h0, err_lock}, 32'h0);
                clear();
            end
        end
        sweep("R8");

        // R10: command offered during busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 1'b0; cmd_addr = 9'h0A0; cmd_data = 16'hFF00;
        m_mem['hA0] = m_mem['hA0] & 16'hFF00;
        @(negedge clk);
        chk("R10", {31'h0, busy}, 32'h1);
        cmd_addr = 9'h000; cmd_data = 16'h0000;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        flags("R10");
        rd('hA0, v); chk("R10", v, m_mem['hA0]);

        sweep("R11");
        done = 1;
        summary();
        $finish;
    end
endmodule